// File: doc/BRIEF.md
# Frame-activity power supervisor

This block watches the timing pulses that a PCM highway controller supplies to a multi-channel voice codec and decides how much of the codec has to be awake. It runs on the master bit clock. It sees one frame-separation pulse per frame and one frame-sync pulse per channel. From these it derives a three-level device mode and one enable line per channel. A channel whose sync has stopped for four frames is switched off. When all channels are off, the device drops to standby. When the frame-separation pulse itself stops for four frames, the device goes to full powerdown.

After reset the block does not yet know the frame length. It measures the distance between two successive frame-separation rising edges. A spacing near 256 clocks identifies a 2.048 MHz master clock, and a spacing near 512 clocks identifies 4.096 MHz. The result is held until the next reset. From then on a free-running frame counter of that length produces the frame boundaries against which missing pulses are counted. Any pulse that reappears clears its miss count on the clock edge that samples it. The corresponding channel or device state therefore returns at once and no frame is lost.

Top module: `frame_power_supervisor`

## Requirements
- R1: While reset is asserted and until the rate is locked, mode_o is 2'b00 (powerdown), chan_en_o is all zero and rate_lock_o is 0.
- R2: The clock rate is locked at the clock edge that samples the second rising edge of fsep_i, if the rising-edge spacing is within RATE_TOL of SHORT_FRAME (rate_fast_o=0) or of LONG_FRAME (rate_fast_o=1). Any other spacing leaves rate_lock_o at 0.
- R3: Once locked, rate_lock_o and rate_fast_o hold their values until the next reset, whatever fsep_i does.
- R4: Once locked, frame boundaries fall every SHORT_FRAME or LONG_FRAME clocks, counted from the locking edge. A channel whose sync shows no rising edge across MISS_LIMIT (4) consecutive frame boundaries is disabled. With three misses the channel stays enabled.
- R5: A rising edge of fsync_i[n] re-enables channel n in the cycle after the edge that samples it, provided the device is not in powerdown.
- R6: With the frame-separation pulse present and every channel disabled, mode_o is 2'b01 (standby).
- R7: When fsep_i shows no rising edge across four consecutive frame boundaries, mode_o becomes 2'b00 and every channel enable is forced low.
- R8: A rising edge of fsep_i after powerdown returns the device to standby or powerup in the very next cycle. Channels whose sync kept arriving are enabled again at the same time.
- R9: mode_o is 2'b10 (powerup) exactly when the device is locked, the frame-separation pulse is present and at least one channel is enabled. The code 2'b11 never occurs.
- R10: Only rising edges count as presence. A sync held high for many frames counts once and then ages out like a missing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master bit clock, the time base |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsep_i | input | 1 | Frame-separation pulse, synchronous to clk_i |
| fsync_i | input | NUM_CH | Per-channel frame-sync pulses, synchronous to clk_i |
| mode_o | output | 2 | Device mode: 00 powerdown, 01 standby, 10 powerup |
| chan_en_o | output | NUM_CH | Per-channel enable |
| rate_fast_o | output | 1 | 1 when the long (4.096 MHz) frame was detected |
| rate_lock_o | output | 1 | Clock rate has been determined |

## Verification
Every result of this block is due in the cycle right after the clock edge that samples the causing input. This holds for the lock flag at the second separation edge, for a channel enable coming back after its sync edge, for the mode leaving powerdown after a separation edge, and for an enable dropping at the fourth empty frame boundary. The bench drives inputs on the falling clock edge and steps its behavioural model on the rising edge. It compares all outputs on the following falling edge, so every comparison lands exactly in the cycle the result is due. For reappearance, the targeted checks also confirm that the output is still low in the cycle before, which pins the latency to exactly one edge.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_ACTIVE  = 2'b10
  } pwr_mode_e;
endpackage

// File: rtl/fps_edge_det.sv
module fps_edge_det #(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/fps_rate_detect.sv
module fps_rate_detect #(
  parameter int SHORT_FRAME = 256,
  parameter int LONG_FRAME  = 512,
  parameter int RATE_TOL    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sep_rise_i,
  output logic lock_now_o,
  output logic lock_o,
  output logic fast_o
);
  localparam int PW = $clog2(LONG_FRAME + RATE_TOL + 2) + 1;
  localparam logic [PW-1:0] S_LO = PW'(SHORT_FRAME - RATE_TOL);
  localparam logic [PW-1:0] S_HI = PW'(SHORT_FRAME + RATE_TOL);
  localparam logic [PW-1:0] L_LO = PW'(LONG_FRAME - RATE_TOL);
  localparam logic [PW-1:0] L_HI = PW'(LONG_FRAME + RATE_TOL);

  logic [PW-1:0] per_q, span;
  logic          armed_q, lock_q, fast_q;
  logic          near_short, near_long;

  assign span       = per_q + PW'(1);
  assign near_short = (span >= S_LO) && (span <= S_HI);
  assign near_long  = (span >= L_LO) && (span <= L_HI);
  assign lock_now_o = !lock_q && armed_q && sep_rise_i && (near_short || near_long);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q   <= '0;
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
      fast_q  <= 1'b0;
    end else if (!lock_q) begin
      if (sep_rise_i) begin
        armed_q <= 1'b1;
        per_q   <= '0;
        if (lock_now_o) begin
          lock_q <= 1'b1;
          fast_q <= near_long && !near_short;
        end
      end else if (per_q != '1) begin
        per_q <= per_q + PW'(1);
      end
    end
  end

  assign lock_o = lock_q;
  assign fast_o = fast_q;
endmodule

// File: rtl/fps_frame_timer.sv
module fps_frame_timer #(
  parameter int SHORT_FRAME = 256,
  parameter int LONG_FRAME  = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic lock_now_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int CW = $clog2(LONG_FRAME);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_FRAME - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_FRAME - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = fast_i ? LONG_LAST : SHORT_LAST;
  assign tick_o = lock_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (lock_now_i) cnt_q <= '0;
    else if (lock_i)     cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/fps_miss_tracker.sv
module fps_miss_tracker #(
  parameter int MISS_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic tick_i,
  output logic alive_o
);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [MW-1:0] LIMIT = MW'(MISS_LIMIT);

  logic [MW-1:0] miss_q;
  logic          seen_q;

  // start saturated: nothing is alive until its pulse is observed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q <= LIMIT;
      seen_q <= 1'b0;
    end else if (tick_i) begin
      seen_q <= 1'b0;
      if (rise_i || seen_q)   miss_q <= '0;
      else if (miss_q != LIMIT) miss_q <= miss_q + MW'(1);
    end else if (rise_i) begin
      seen_q <= 1'b1;
      miss_q <= '0;
    end
  end

  assign alive_o = (miss_q != LIMIT);
endmodule

// File: rtl/frame_power_supervisor.sv
module frame_power_supervisor
  import fps_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SHORT_FRAME = 256,
  parameter int LONG_FRAME  = 512,
  parameter int RATE_TOL    = 8,
  parameter int MISS_LIMIT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsep_i,
  input  logic [NUM_CH-1:0] fsync_i,
  output logic [1:0]        mode_o,
  output logic [NUM_CH-1:0] chan_en_o,
  output logic              rate_fast_o,
  output logic              rate_lock_o
);
  localparam int NSRC = NUM_CH + 1;
  localparam int SEP  = NSRC - 1;

  logic [NSRC-1:0] pulses, rises, alive;
  logic            tick, lock_now, sep_ok;
  pwr_mode_e       mode_s;

  assign pulses = {fsep_i, fsync_i};

  fps_edge_det #(.WIDTH(NSRC)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pulses),
    .rise_o  (rises)
  );

  fps_rate_detect #(
    .SHORT_FRAME (SHORT_FRAME),
    .LONG_FRAME  (LONG_FRAME),
    .RATE_TOL    (RATE_TOL)
  ) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sep_rise_i (rises[SEP]),
    .lock_now_o (lock_now),
    .lock_o     (rate_lock_o),
    .fast_o     (rate_fast_o)
  );

  fps_frame_timer #(
    .SHORT_FRAME (SHORT_FRAME),
    .LONG_FRAME  (LONG_FRAME)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (rate_lock_o),
    .lock_now_i (lock_now),
    .fast_i     (rate_fast_o),
    .tick_o     (tick)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_trk
    fps_miss_tracker #(.MISS_LIMIT(MISS_LIMIT)) u_trk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rises[g]),
      .tick_i  (tick),
      .alive_o (alive[g])
    );
  end

  assign sep_ok    = rate_lock_o & alive[SEP];
  assign chan_en_o = {NUM_CH{sep_ok}} & alive[NUM_CH-1:0];

  always_comb begin
    if (!sep_ok)         mode_s = MODE_OFF;
    else if (|chan_en_o) mode_s = MODE_ACTIVE;
    else                 mode_s = MODE_STANDBY;
  end

  assign mode_o = mode_s;
endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fsep_i,
  input logic [NUM_CH-1:0] fsync_i,
  input logic [1:0]        mode_o,
  input logic [NUM_CH-1:0] chan_en_o,
  input logic              rate_fast_o,
  input logic              rate_lock_o
);
  logic              sep_prev;
  logic [NUM_CH-1:0] sync_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sep_prev  <= 1'b0;
      sync_prev <= '0;
    end else begin
      sep_prev  <= fsep_i;
      sync_prev <= fsync_i;
    end
  end

  AST_UNLOCKED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rate_lock_o |-> (mode_o == MODE_OFF && chan_en_o == '0)); // R1

  AST_RATE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_lock_o |=> (rate_lock_o && $stable(rate_fast_o))); // R3

  AST_OFF_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_OFF) |-> (chan_en_o == '0)); // R7

  AST_SEP_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_lock_o && fsep_i && !sep_prev) |=> (mode_o != MODE_OFF)); // R8

  AST_EN_MEANS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_o != '0) |-> (mode_o == MODE_ACTIVE)); // R9

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11); // R9

  AST_STANDBY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_STANDBY) |-> (rate_lock_o && chan_en_o == '0)); // R6

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_SYNC_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_lock_o && fsync_i[c] && !sync_prev[c]) |=>
        (mode_o == MODE_OFF || chan_en_o[c])); // R5
  end
endmodule

bind frame_power_supervisor fps_checker #(.NUM_CH(NUM_CH)) u_fps_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fsep_i      (fsep_i),
  .fsync_i     (fsync_i),
  .mode_o      (mode_o),
  .chan_en_o   (chan_en_o),
  .rate_fast_o (rate_fast_o),
  .rate_lock_o (rate_lock_o)
);

// File: tb/sim_frame_power_supervisor.sv
`timescale 1ns/1ps
module sim_frame_power_supervisor;
  localparam int NCH = 4, SF = 256, LF = 512, TOL = 8, ML = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           fsep_i = 1'b0;
  logic [NCH-1:0] fsync_i = '0;
  logic [1:0]     mode_o;
  logic [NCH-1:0] chan_en_o;
  logic           rate_fast_o, rate_lock_o;

  always #4 clk_i = ~clk_i;

  frame_power_supervisor #(
    .NUM_CH(NCH), .SHORT_FRAME(SF), .LONG_FRAME(LF), .RATE_TOL(TOL), .MISS_LIMIT(ML)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsep_i(fsep_i), .fsync_i(fsync_i),
    .mode_o(mode_o), .chan_en_o(chan_en_o), .rate_fast_o(rate_fast_o), .rate_lock_o(rate_lock_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // stimulus state
  int per = SF, ph = 0, last_ph = 0, sep_w = 1;
  bit sep_on = 0;
  bit fy_on[NCH];
  int fy_slot[NCH];
  int fy_w[NCH];

  // behavioural model, index NCH is the separation pulse
  bit m_prev[NCH+1];
  bit m_seen[NCH+1];
  int m_miss[NCH+1];
  bit m_locked, m_fast, m_armed;
  int m_per, m_cnt;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i <= NCH; i++) begin
      m_prev[i] = 0; m_seen[i] = 0; m_miss[i] = ML;
    end
    m_locked = 0; m_fast = 0; m_armed = 0; m_per = 0; m_cnt = 0;
  endfunction

  function automatic void m_update(bit fs, logic [NCH-1:0] fy);
    bit lv[NCH+1];
    bit rs[NCH+1];
    bit tk;
    int len, meas;
    for (int i = 0; i < NCH; i++) lv[i] = fy[i];
    lv[NCH] = fs;
    for (int i = 0; i <= NCH; i++) rs[i] = lv[i] && !m_prev[i];
    len = m_fast ? LF : SF;
    tk = m_locked && (m_cnt == len - 1);
    if (!m_locked) begin
      if (rs[NCH]) begin
        if (m_armed) begin
          meas = m_per + 1;
          if (meas >= SF - TOL && meas <= SF + TOL) begin
            m_locked = 1; m_fast = 0; m_cnt = 0;
          end else if (meas >= LF - TOL && meas <= LF + TOL) begin
            m_locked = 1; m_fast = 1; m_cnt = 0;
          end
        end
        m_armed = 1; m_per = 0;
      end else if (m_per < 4000) m_per++;
    end else begin
      m_cnt = tk ? 0 : m_cnt + 1;
    end
    for (int i = 0; i <= NCH; i++) begin
      if (tk) begin
        if (rs[i] || m_seen[i]) m_miss[i] = 0;
        else if (m_miss[i] < ML) m_miss[i]++;
        m_seen[i] = 0;
      end else if (rs[i]) begin
        m_miss[i] = 0; m_seen[i] = 1;
      end
      m_prev[i] = lv[i];
    end
  endfunction

  function automatic int e_en();
    int v = 0;
    if (m_locked && m_miss[NCH] < ML)
      for (int i = 0; i < NCH; i++) if (m_miss[i] < ML) v |= (1 << i);
    return v;
  endfunction

  function automatic int e_mode();
    if (!(m_locked && m_miss[NCH] < ML)) return 0;
    return (e_en() != 0) ? 2 : 1;
  endfunction

  task automatic step();
    @(posedge clk_i);
    if (!rst_ni) m_reset();
    else m_update(fsep_i, fsync_i);
    @(negedge clk_i);
    chk("R9 mode vs model", int'(mode_o), e_mode());
    chk("R4 enables vs model", int'(chan_en_o), e_en());
    chk("R2 lock vs model", int'(rate_lock_o), int'(m_locked));
    chk("R3 rate vs model", int'(rate_fast_o), int'(m_fast));
    fsep_i = sep_on && (ph < sep_w);
    for (int i = 0; i < NCH; i++)
      fsync_i[i] = fy_on[i] && (((ph - fy_slot[i] + per) % per) < fy_w[i]);
    last_ph = ph;
    ph = (ph + 1) % per;
  endtask

  task automatic run_frames(int n);
    repeat (n * per) step();
  endtask

  task automatic do_reset(int new_per);
    @(negedge clk_i);
    rst_ni = 1'b0;
    per = new_per;
    ph = 0;
    repeat (3) step();
    chk("R1 reset mode", int'(mode_o), 0);
    chk("R1 reset enables", int'(chan_en_o), 0);
    chk("R1 reset lock", int'(rate_lock_o), 0);
    rst_ni = 1'b1;
    ph = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    m_reset();
    fy_slot[0] = 10; fy_slot[1] = 50; fy_slot[2] = 100; fy_slot[3] = 200;
    for (int i = 0; i < NCH; i++) begin fy_on[i] = 1; fy_w[i] = 1; end
    sep_on = 1;

    // short frame lock and full powerup
    do_reset(SF);
    chk("R1 unlocked mode after release", int'(mode_o), 0);
    run_frames(4);
    chk("R2 short lock", int'(rate_lock_o), 1);
    chk("R2 short rate", int'(rate_fast_o), 0);
    chk("R9 powerup mode", int'(mode_o), 2);
    chk("R9 all enabled", int'(chan_en_o), 'hf);

    // channel 2 ages out after four empty boundaries
    fy_on[2] = 0;
    run_frames(4);
    chk("R4 three misses keep enable", int'(chan_en_o), 'hf);
    run_frames(1);
    chk("R4 fourth miss disables", int'(chan_en_o), 'hb);
    chk("R9 still powerup", int'(mode_o), 2);

    // immediate return of channel 2
    fy_on[2] = 1;
    do step(); while (last_ph != fy_slot[2]);
    chk("R5 before sampling edge", int'(chan_en_o[2]), 0);
    step();
    chk("R5 enabled next cycle", int'(chan_en_o[2]), 1);

    // held-high sync counts once
    fy_w[1] = per;
    run_frames(6);
    chk("R10 held sync ages out", int'(chan_en_o[1]), 0);
    fy_w[1] = 1;
    run_frames(1);
    chk("R10 fresh edge restores", int'(chan_en_o[1]), 1);

    // all syncs gone -> standby
    for (int i = 0; i < NCH; i++) fy_on[i] = 0;
    run_frames(6);
    chk("R6 standby mode", int'(mode_o), 1);
    chk("R6 no enables", int'(chan_en_o), 0);
    for (int i = 0; i < NCH; i++) fy_on[i] = 1;
    run_frames(1);
    chk("R9 back to powerup", int'(mode_o), 2);

    // separation pulse gone -> powerdown, then immediate recovery
    sep_on = 0;
    run_frames(5);
    chk("R7 powerdown mode", int'(mode_o), 0);
    chk("R7 enables forced low", int'(chan_en_o), 0);
    chk("R3 lock kept without separation", int'(rate_lock_o), 1);
    sep_on = 1;
    do step(); while (last_ph != 0);
    chk("R8 before sampling edge", int'(mode_o), 0);
    step();
    chk("R8 mode restored", int'(mode_o), 2);
    chk("R8 enables restored", int'(chan_en_o), 'hf);

    // spacing matching neither rate
    do_reset(300);
    run_frames(4);
    chk("R2 no lock on odd spacing", int'(rate_lock_o), 0);
    chk("R1 stays powerdown", int'(mode_o), 0);

    // long frame with a wide separation pulse
    sep_w = 5;
    do_reset(LF);
    run_frames(4);
    chk("R2 long lock", int'(rate_lock_o), 1);
    chk("R2 long rate", int'(rate_fast_o), 1);
    chk("R9 long powerup", int'(mode_o), 2);
    chk("R9 long enables", int'(chan_en_o), 'hf);
    per = SF;
    ph = 0;
    run_frames(3);
    chk("R3 rate held after spacing change", int'(rate_fast_o), 1);
    chk("R3 lock held", int'(rate_lock_o), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule